// File: doc/BRIEF.md
# Break and Sync Baud-Rate Trainer

This block learns the bit period of an asynchronous serial line from a training preamble, so that a downstream UART receiver can be loaded with the right divisor. The preamble starts with a break, which is a low level held longer than any legal character could hold it. A sync character 0x55 follows the break. The trainer first hunts for the break. It then times the sync character in system clock cycles and reports the measured bit period.

The line idles high. The 0x55 frame is sent LSB first, so the start bit and the data bits alternate in level, and a falling edge occurs every two bit times. The block times the four intervals between consecutive falling edges, from the start-bit edge to the falling edge that opens data bit 7. Together those four intervals span eight bit times, and the block divides their sum by eight.

It checks that the four intervals agree with one another. It reports either a one-cycle done strobe together with the period, or a one-cycle error strobe. It does not receive data itself.

Top module: `baud_trainer`

## Requirements
- R1: While reset is asserted, and after it is released, `done` and `err` are 0 and `bit_period` is 0.
- R2: A break is recognised once `rx` has been sampled low on `BREAK_CLKS` consecutive clocks. A low run that is shorter than this does not arm measurement, so a sync character that follows such a run produces neither `done` nor `err`.
- R3: After a break, the first falling edge after `rx` returns high starts the measurement. `bit_period` is the floor of (clocks from that edge to the fourth falling edge after it) divided by 8.
- R4: `done` is high for exactly one cycle. If `rx` changes before rising edge n, a falling edge at that point raises `done` between edges n+1 and n+2.
- R5: `bit_period` changes only in the cycle in which `done` rises, and holds its value otherwise.
- R6: The first interval between falling edges is the reference. If interval 2, 3 or 4 differs from the reference by more than floor(reference/8) clocks, `err` pulses for one cycle in place of `done`. A difference equal to floor(reference/8) is accepted.
- R7: While the block is waiting for a sync falling edge, either the start edge or a later edge, `TIMEOUT_CLKS-1` clocks without a falling edge raise `err` for one cycle, and the block returns to break hunting.
- R8: A break seen at any point, including in the middle of a measurement, aborts that measurement without `done` or `err` and restarts training.
- R9: `done` and `err` are never high together.
- R10: After `done` or `err`, the block hunts for a new break. A sync character with no break before it produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx | input | 1 | Serial line, idle high, synchronous to clk |
| done | output | 1 | One-cycle strobe when a valid period is measured |
| err | output | 1 | One-cycle strobe on malformed sync or timeout |
| bit_period | output | CNT_W | Last measured bit period in clocks |

## Verification
The sync character is sent in several forms:
- Uniform bit widths of 40, 37 and 64 clocks. These show that the divide-by-eight result tracks the line rate.
- A stretched data bit 3, placed exactly at the quarter-bit limit and one clock past it. These separate accepting from rejecting at the tolerance edge, and also show the floor in the division.

A low glitch shorter than a break, an idle line that runs past the timeout, a break that lands in the middle of a sync, and a sync with no break before it show that only a full break arms measurement, and that every outcome returns the block to hunting. A behavioural reference model driven by recorded falling-edge timestamps is compared with the outputs on every clock.

// File: rtl/baud_trainer.sv
module baud_trainer #(
  parameter int CNT_W        = 16,
  parameter int BREAK_CLKS   = 1100,
  parameter int TIMEOUT_CLKS = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] bit_period
);
  localparam int TW = CNT_W + 2;
  localparam logic [CNT_W-1:0] BRK_LAST = CNT_W'(BREAK_CLKS - 1);
  localparam logic [CNT_W-1:0] BRK_SAT  = CNT_W'(BREAK_CLKS);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_CLKS - 1);

  typedef enum logic [1:0] {HUNT, BRK, WAIT, MEAS} st_t;
  st_t st;

  logic             s0, s1, bad;
  logic [CNT_W-1:0] low_cnt, seg, first;
  logic [TW-1:0]    tot;
  logic [1:0]       nfall;

  wire             fall    = s1 & ~s0;
  wire             brk_hit = ~s0 && (low_cnt == BRK_LAST);
  wire [CNT_W-1:0] dlt     = (seg > first) ? seg - first : first - seg;
  wire             bad_n   = bad | ((nfall != 2'd0) && (dlt > (first >> 3)));
  wire [TW-1:0]    tot_n   = tot + TW'(seg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HUNT;
      s0 <= 1'b1;
      s1 <= 1'b1;
      low_cnt <= '0;
      seg <= '0;
      first <= '0;
      tot <= '0;
      nfall <= '0;
      bad <= 1'b0;
      done <= 1'b0;
      err <= 1'b0;
      bit_period <= '0;
    end else begin
      s0 <= rx;
      s1 <= s0;
      done <= 1'b0;
      err <= 1'b0;
      if (s0) low_cnt <= '0;
      else if (low_cnt != BRK_SAT) low_cnt <= low_cnt + 1'b1;

      if (brk_hit) st <= BRK;
      else begin
        case (st)
          BRK: if (s0) begin
            st <= WAIT;
            seg <= CNT_W'(1);
          end
          WAIT: if (fall) begin
            st <= MEAS;
            seg <= CNT_W'(1);
            tot <= '0;
            nfall <= '0;
            bad <= 1'b0;
          end else if (seg == TO_LAST) begin
            err <= 1'b1;
            st <= HUNT;
          end else seg <= seg + 1'b1;
          MEAS: if (fall) begin
            seg <= CNT_W'(1);
            tot <= tot_n;
            nfall <= nfall + 1'b1;
            bad <= bad_n;
            if (nfall == 2'd0) first <= seg;
            if (nfall == 2'd3) begin
              st <= HUNT;
              if (bad_n) err <= 1'b1;
              else begin
                done <= 1'b1;
                bit_period <= CNT_W'(tot_n >> 3);
              end
            end
          end else if (seg == TO_LAST) begin
            err <= 1'b1;
            st <= HUNT;
          end else seg <= seg + 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/baud_trainer_chk.sv
module baud_trainer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             err,
  input logic [CNT_W-1:0] bit_period
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!done && !err && bit_period == '0));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(bit_period)));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind baud_trainer baud_trainer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .bit_period(bit_period)
);

// File: tb/baud_trainer_tb.sv
module baud_trainer_tb_top;
  localparam int CNT_W = 16;
  localparam int BRK   = 1100;
  localparam int TO    = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic done, err;
  logic [CNT_W-1:0] bit_period;

  int tests = 0;
  int fails = 0;
  int n_done = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  baud_trainer #(.CNT_W(CNT_W), .BREAK_CLKS(BRK), .TIMEOUT_CLKS(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx(rx), .done(done), .err(err), .bit_period(bit_period)
  );

  // reference model: line samples, phase, falling-edge timestamps
  int  cyc = 0, ph = 0, lowrun = 0, t_ref = 0;
  int  fq[$];
  bit  ln = 1'b1, lp = 1'b1;
  bit  e_done = 1'b0, e_err = 1'b0;
  int  e_per = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; ph = 0; lowrun = 0; t_ref = 0; ln = 1'b1; lp = 1'b1;
      e_done = 1'b0; e_err = 1'b0; e_per = 0; fq.delete();
    end else begin
      bit fall;
      cyc++;
      e_done = 1'b0;
      e_err = 1'b0;
      fall = lp && !ln;
      lowrun = ln ? 0 : lowrun + 1;
      if (lowrun == BRK) ph = 1;
      else if (ph == 1) begin
        if (ln) begin ph = 2; t_ref = cyc; end
      end else if (ph == 2) begin
        if (fall) begin ph = 3; fq.delete(); fq.push_back(cyc); t_ref = cyc; end
        else if (cyc - t_ref == TO - 1) begin e_err = 1'b1; ph = 0; end
      end else if (ph == 3) begin
        if (fall) begin
          fq.push_back(cyc);
          t_ref = cyc;
          if (fq.size() == 5) begin
            int ref_iv;
            bit bad;
            ref_iv = fq[1] - fq[0];
            bad = 1'b0;
            for (int i = 2; i < 5; i++) begin
              int d;
              d = (fq[i] - fq[i-1]) - ref_iv;
              if (d < 0) d = -d;
              if (d > ref_iv / 8) bad = 1'b1;
            end
            if (bad) e_err = 1'b1;
            else begin e_done = 1'b1; e_per = (fq[4] - fq[0]) / 8; end
            ph = 0;
          end
        end else if (cyc - t_ref == TO - 1) begin e_err = 1'b1; ph = 0; end
      end
      lp = ln;
      ln = rx;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (done !== e_done || err !== e_err || int'(bit_period) != e_per) begin
        fails++;
        $display("FAIL R4/R5/R7 model cycle %0d: done=%0b err=%0b per=%0d expected done=%0b err=%0b per=%0d",
                 cyc, done, err, bit_period, e_done, e_err, e_per);
      end
      if (done) n_done++;
      if (err) n_err++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lvl(input bit v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  // 0x55, LSB first: start 0, bits 1,0,1,0,1,0,1,0, stop 1
  task automatic sync55(input int w, input int w3);
    lvl(1'b0, w);
    for (int b = 0; b < 8; b++) lvl(((8'h55 >> b) & 1) != 0, (b == 3) ? w3 : w);
    lvl(1'b1, w);
    lvl(1'b1, 20);
  endtask

  task automatic trained(input int w, input int w3);
    lvl(1'b0, 1200);
    lvl(1'b1, 50);
    sync55(w, w3);
  endtask

  task automatic clr;
    n_done = 0;
    n_err = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 period after reset", int'(bit_period), 0);

    clr(); trained(40, 40);
    chk("R3 done count w40", n_done, 1);
    chk("R3 period w40", int'(bit_period), 40);
    chk("R9 no err w40", n_err, 0);

    clr(); trained(37, 37);
    chk("R3 period w37", int'(bit_period), 37);

    clr(); trained(64, 64);
    chk("R3 period w64", int'(bit_period), 64);

    clr(); trained(40, 50);
    chk("R6 limit accepted", n_done, 1);
    chk("R3 floor period 330/8", int'(bit_period), 41);

    clr(); trained(40, 51);
    chk("R6 over limit err", n_err, 1);
    chk("R6 no done", n_done, 0);
    chk("R5 period held", int'(bit_period), 41);

    clr(); lvl(1'b0, 500); lvl(1'b1, 50); sync55(45, 45);
    chk("R2 short low no done", n_done, 0);
    chk("R2 short low no err", n_err, 0);
    chk("R5 period held after glitch", int'(bit_period), 41);

    clr(); lvl(1'b0, 1200); lvl(1'b1, TO + 100);
    chk("R7 timeout err", n_err, 1);
    clr(); sync55(45, 45);
    chk("R10 no break no done", n_done, 0);
    chk("R10 no break no err", n_err, 0);

    clr(); lvl(1'b0, 1200); lvl(1'b1, 50);
    lvl(1'b0, 40); lvl(1'b1, 40); lvl(1'b0, 1200); lvl(1'b1, 50);
    sync55(50, 50);
    chk("R8 restart done", n_done, 1);
    chk("R8 restart no err", n_err, 0);
    chk("R8 restart period", int'(bit_period), 50);

    clr(); sync55(30, 30);
    chk("R10 after done no strobe", n_done + n_err, 0);
    chk("R5 period kept", int'(bit_period), 50);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule